// File: doc/BRIEF.md
# Serial Clock Freeze Mask Controller

This block decides, for each of fifteen generated clock outputs, whether that output may run or must be held low. It produces one enable level per output. Downstream gating logic consumes these levels and performs the actual clock stop. The block does not gate clocks itself.

Two inputs control the enables.

- **Serial line.** A slow serial line, clocked by its own free-running serial clock, carries a framed 13-bit freeze mask. Each mask bit controls one output. Two outputs have no mask bit.
- **Common-freeze level and strobe.** A common-freeze level is applied to all fifteen outputs at once when a strobe input falls.

All four control inputs are treated as asynchronous. They pass through a synchroniser into the output clock domain, so every enable changes on that clock. The serial clock edges and the strobe edges are detected in that domain. The serial clock must therefore be several times slower than the block clock.

The last event decides each output's enable. That event is either a completed frame, for the masked outputs, or a strobe, for all outputs. After reset every output is enabled.

Top module: `frz_mask_ctrl`

## Requirements
- R1: After reset every bit of `out_en_o` is 1 (all outputs running). A reset that arrives part-way through a frame also leaves all enables at 1.
- R2: A frame is a 0 start bit followed by 13 data bits D0..D12. Each bit is sampled on a rising edge of `ser_clk_i`, one bit per serial clock period.
- R3: When a frame completes, each data bit sets one enable: 0 freezes the output and 1 lets it run.
  - D0..D2 drive `out_en_o[0]..[2]`.
  - D3..D6 drive `out_en_o[4]..[7]`.
  - D7..D12 drive `out_en_o[9]..[14]`.
- R4: A frame changes no enable before its last bit D12 is sampled. The enables then change together. A frame cut off by reset has no effect, and the next frame is received from its own start bit.
- R5: `out_en_o[3]` and `out_en_o[8]` are never changed by a serial frame.
- R6: On a falling edge of `frz_strobe_i`, all fifteen enables take the level of `frz_common_i` (0 freezes all, 1 releases all). A rising edge of the strobe changes nothing.
- R7: Each enable follows whichever update came last: a frame (for the masked outputs) or a strobe. If both land in the same cycle, the strobe wins.
- R8: After D12, the receiver ignores 0 bits until it has sampled a 1 on the line. Only then does it accept a new start bit.
- R9: While the line is idle at 1, serial clock edges change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock; all enables change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Free-running serial clock for the mask line (asynchronous) |
| ser_dat_i | input | 1 | Serial mask data line; idles at 1 (asynchronous) |
| frz_strobe_i | input | 1 | Strobe; its falling edge applies the common level (asynchronous) |
| frz_common_i | input | 1 | Common freeze level: 0 freeze all, 1 release all |
| out_en_o | output | 15 | Per-output enable, 1 = running, 0 = held low |

## Verification
The bench sends three kinds of mask:
- an alternating mask, which shows that no two data bits are swapped or shifted onto a neighbouring output;
- an all-zero mask, which separates the two exempt outputs from the masked ones;
- a mask with only the end bits D0 and D12 set, which exposes an off-by-one in the bit count.

Further sequences check the other rules:
- A frame that stops one bit short shows whether the update is held back until the last bit.
- A frame cut by reset shows whether a partial frame is discarded and the bit counter restarts.
- A long run of zeros straight after a frame with no stop bit shows whether the receiver wrongly restarts before it sees a 1.
- Strobe-then-frame and frame-then-strobe orderings check that the later update wins, while the exempt outputs keep the strobe's level.

// File: rtl/frz_mask_pkg.sv
package frz_mask_pkg;

  localparam int unsigned MASK_W    = 13;
  localparam int unsigned OUT_W     = MASK_W + 2;
  localparam int unsigned EXEMPT_LO = 3;
  localparam int unsigned EXEMPT_HI = 8;
  localparam int unsigned CNT_W     = $clog2(MASK_W);

  typedef enum logic [1:0] {
    RX_HUNT    = 2'd0,
    RX_SHIFT   = 2'd1,
    RX_RELEASE = 2'd2
  } rx_state_e;

  // Place mask bits onto the non-exempt outputs in ascending order; the
  // exempt outputs keep the value from hold_v.
  function automatic logic [OUT_W-1:0] spread_mask(
    input logic [MASK_W-1:0] mask_v,
    input logic [OUT_W-1:0]  hold_v
  );
    logic [OUT_W-1:0] res;
    int unsigned      j;
    res = hold_v;
    j   = 0;
    for (int unsigned k = 0; k < OUT_W; k++) begin
      if (k != EXEMPT_LO && k != EXEMPT_HI) begin
        res[k] = mask_v[j];
        j      = j + 1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/frz_sync.sv
module frz_sync #(
  parameter int unsigned    W       = 4,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/frz_frame_rx.sv
module frz_frame_rx
  import frz_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick_i,
  input  logic              bit_val_i,
  output logic              frame_done_o,
  output logic [MASK_W-1:0] frame_bits_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MASK_W - 1);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [MASK_W-1:0] shf_q, shf_n;
  logic              done_q, done_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    shf_n   = shf_q;
    done_n  = 1'b0;
    if (bit_tick_i) begin
      unique case (state_q)
        RX_HUNT: begin
          if (!bit_val_i) begin
            state_n = RX_SHIFT;
            cnt_n   = '0;
          end
        end
        RX_SHIFT: begin
          shf_n[cnt_q] = bit_val_i;
          if (cnt_q == LAST_IDX) begin
            done_n  = 1'b1;
            state_n = RX_RELEASE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_RELEASE: begin
          if (bit_val_i) state_n = RX_HUNT;
        end
        default: state_n = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      shf_q   <= '1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      shf_q   <= shf_n;
      done_q  <= done_n;
    end
  end

  assign frame_done_o = done_q;
  assign frame_bits_o = shf_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2

  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_RELEASE && bit_tick_i && !bit_val_i) |=> state_q == RX_RELEASE); // R8

endmodule

// File: rtl/frz_enable_merge.sv
module frz_enable_merge
  import frz_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done_i,
  input  logic [MASK_W-1:0] frame_bits_i,
  input  logic              strobe_fall_i,
  input  logic              common_lvl_i,
  output logic [OUT_W-1:0]  en_o
);

  logic [OUT_W-1:0] en_q, en_n;

  always_comb begin
    en_n = en_q;
    if (frame_done_i)  en_n = spread_mask(frame_bits_i, en_q);
    if (strobe_fall_i) en_n = {OUT_W{common_lvl_i}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_n;
  end

  assign en_o = en_q;

  AST_STROBE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fall_i |=> en_o == {OUT_W{$past(common_lvl_i)}}); // R6

  AST_EXEMPT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_fall_i |=> $stable(en_o[EXEMPT_LO]) && $stable(en_o[EXEMPT_HI])); // R5

  AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_i && !strobe_fall_i) |=>
      (en_o[0] == $past(frame_bits_i[0])) && (en_o[4] == $past(frame_bits_i[3])) &&
      (en_o[OUT_W-1] == $past(frame_bits_i[MASK_W-1]))); // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done_i && !strobe_fall_i) |=> $stable(en_o)); // R4

endmodule

// File: rtl/frz_mask_ctrl.sv
module frz_mask_ctrl
  import frz_mask_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             frz_strobe_i,
  input  logic             frz_common_i,
  output logic [OUT_W-1:0] out_en_o
);

  localparam int unsigned IN_W = 4;

  logic [IN_W-1:0]  raw_in, syn_in;
  logic             sclk_prev_q, strb_prev_q;
  logic             bit_tick, strobe_fall;
  logic             frame_done;
  logic [MASK_W-1:0] frame_bits;

  assign raw_in = {ser_clk_i, ser_dat_i, frz_strobe_i, frz_common_i};

  frz_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1101)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b1;
      strb_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= syn_in[3];
      strb_prev_q <= syn_in[1];
    end
  end

  assign bit_tick    = syn_in[3] & ~sclk_prev_q;
  assign strobe_fall = ~syn_in[1] & strb_prev_q;

  frz_frame_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick_i   (bit_tick),
    .bit_val_i    (syn_in[2]),
    .frame_done_o (frame_done),
    .frame_bits_o (frame_bits)
  );

  frz_enable_merge u_merge (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_done_i  (frame_done),
    .frame_bits_i  (frame_bits),
    .strobe_fall_i (strobe_fall),
    .common_lvl_i  (syn_in[0]),
    .en_o          (out_en_o)
  );

  AST_TICK_STROBE_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R2

endmodule

// File: tb/frz_mask_ctrl_tb_top.sv
module frz_mask_ctrl_tb_top;

  localparam int HALF = 6;

  logic        clk;
  logic        rst_n;
  logic        ser_clk, ser_dat, strobe, common;
  logic [14:0] en;
  logic [14:0] exp_en;
  int          n_chk;
  int          n_fail;
  bit          finished;

  frz_mask_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_clk_i    (ser_clk),
    .ser_dat_i    (ser_dat),
    .frz_strobe_i (strobe),
    .frz_common_i (common),
    .out_en_o     (en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag);
    n_chk++;
    if (en !== exp_en) begin
      n_fail++;
      $display("FAIL %s: out_en actual=%b expected=%b", tag, en, exp_en);
    end
  endtask

  function automatic logic [14:0] apply_mask(input logic [12:0] m, input logic [14:0] old);
    logic [14:0] r;
    r = old;
    for (int d = 0; d < 13; d++) begin
      if (d < 3)      r[d]     = m[d];
      else if (d < 7) r[d + 1] = m[d];
      else            r[d + 2] = m[d];
    end
    return r;
  endfunction

  task automatic ser_bit(input logic b);
    ser_dat = b;
    tick(HALF);
    ser_clk = 1'b1;
    tick(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [12:0] m, input bit stop);
    ser_bit(1'b0);
    for (int i = 0; i < 13; i++) ser_bit(m[i]);
    if (stop) ser_bit(1'b1);
    tick(4);
    exp_en = apply_mask(m, exp_en);
  endtask

  task automatic do_strobe(input logic lvl);
    common = lvl;
    tick(4);
    strobe = 1'b1;
    tick(HALF);
    strobe = 1'b0;
    tick(8);
    exp_en = {15{lvl}};
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    ser_clk = 1'b0;
    ser_dat = 1'b1;
    strobe  = 1'b0;
    common  = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    exp_en = '1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) ser_bit(1'b1);
    tick(4);
    chk("R9 idle line");
  endtask

  task automatic t_patterns();
    send_frame(13'b1010101010101, 1'b1);
    chk("R2 R3 alternating mask");
    send_frame(13'b0000000000000, 1'b1);
    chk("R5 all-zero mask keeps exempt outputs");
    send_frame(13'b1000000000001, 1'b1);
    chk("R3 end bits D0 D12");
  endtask

  task automatic t_atomic();
    logic [12:0] m;
    m = 13'h1FFF;
    send_frame(13'h0000, 1'b1);
    ser_bit(1'b0);
    for (int i = 0; i < 12; i++) ser_bit(m[i]);
    tick(4);
    chk("R4 no change before last bit");
    ser_bit(m[12]);
    ser_bit(1'b1);
    tick(4);
    exp_en = apply_mask(m, exp_en);
    chk("R4 update after last bit");
  endtask

  task automatic t_partial_reset();
    send_frame(13'h0000, 1'b1);
    ser_bit(1'b0);
    for (int i = 0; i < 5; i++) ser_bit(1'b0);
    do_reset();
    chk("R1 R4 reset mid-frame");
    send_frame(13'b0110011001100, 1'b1);
    chk("R4 frame after discarded partial");
  endtask

  task automatic t_strobe();
    send_frame(13'h0000, 1'b1);
    do_strobe(1'b1);
    chk("R6 strobe releases all");
    common = 1'b0;
    tick(4);
    strobe = 1'b1;
    tick(10);
    chk("R6 rising strobe ignored");
    strobe = 1'b0;
    tick(8);
    exp_en = '0;
    chk("R6 strobe freezes all");
  endtask

  task automatic t_order();
    do_strobe(1'b0);
    send_frame(13'h1FFF, 1'b1);
    chk("R7 frame after freeze strobe, R5 exempt stay 0");
    do_strobe(1'b1);
    send_frame(13'b0000011110000, 1'b1);
    do_strobe(1'b0);
    chk("R7 strobe after frame");
  endtask

  task automatic t_release();
    do_strobe(1'b1);
    send_frame(13'b1010101010101, 1'b0);
    for (int i = 0; i < 14; i++) ser_bit(1'b0);
    tick(4);
    chk("R8 zeros after frame not a start");
    ser_bit(1'b1);
    send_frame(13'b0101010101010, 1'b1);
    chk("R8 frame accepted after line high");
  endtask

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    finished = 0;
    exp_en   = '1;
    t_reset();
    t_idle();
    t_patterns();
    t_atomic();
    t_partial_reset();
    t_strobe();
    t_order();
    t_release();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule